// File: doc/BRIEF.md
# Byte-Port Bus Master Bridge

This block gives an external controller that only has an 8-bit parallel port the ability to run single-word read and write cycles on a 32-bit memory-mapped bus. The controller selects one of sixteen byte registers with a 4-bit select, then strobes a byte in or reads a byte out. To run a cycle, it loads the target address and, for a write, the word to store. Each of these takes four byte writes. It then writes a command byte.

The bridge then drives one request on the bus and holds it there until the slave stops asserting wait-request. It clears a pollable busy flag when that happens. For a read, the word returned by the slave lands in the data register, and the controller fetches it one byte at a time. Because the bridge is an ordinary bus master, the controller can inspect memory and peripheral registers while the rest of the system keeps running.

A three-state machine sequences the bus side. The states are IDLE, READ_REQ and WRITE_REQ. The transitions are:
- IDLE goes to READ_REQ when a command byte arrives with bit 0 set and bit 1 clear.
- IDLE goes to WRITE_REQ when a command byte arrives with bits 0 and 1 both set.
- READ_REQ goes back to IDLE on the first clock where wait-request is low.
- WRITE_REQ goes back to IDLE on the first clock where wait-request is low.
- In every other case, the current state holds.

Top module: `hostbus_bridge`

## Requirements
- R1: After reset the busy flag is 0, neither bus strobe is asserted, and the address and data registers read as zero.
- R2: Host writes to selects 0 to 3 load the address register, little-endian: select 0 is bits 7:0 and select 3 is bits 31:24. The same selects read those bytes back, and `bus_addr` always shows the register.
- R3: Host writes to selects 4 to 7 load the data register, little-endian: select 4 is bits 7:0. The same selects read it back, and `bus_wdata` always shows it.
- R4: A host write to select 8 is the command. Bit 0 is go and bit 1 is direction, where 1 means write and 0 means read. With bit 0 set while idle, exactly the matching strobe is asserted from the next clock. With bit 0 clear, no cycle starts.
- R5: Reading select 9 returns the status byte, whose bit 0 is busy and whose other bits are zero. Busy is 1 from the clock after go until the clock edge on which the request is accepted (wait-request low), and 0 after that edge.
- R6: While a strobe is asserted and wait-request is high, the address, write data and strobes stay unchanged.
- R7: On the acceptance edge of a read, the data register captures `bus_rdata`. Selects 4 to 7 then return that word.
- R8: A command written while busy is ignored. The cycle in flight keeps its direction and is not restarted.
- R9: Host writes to selects 0 to 7 while busy are ignored. The registers and bus outputs keep their values.
- R10: The read and write strobes are never asserted together.
- R11: Selects 8 and 10 to 15 read as zero. Host writes to selects 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both host and bus sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 4 | Host register select |
| host_wr | input | 1 | Host write strobe, one clock per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the selected register (combinational) |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_read | output | 1 | Bus read request |
| bus_write | output | 1 | Bus write request |
| bus_waitreq | input | 1 | Slave stall; the request is accepted on a clock where this is low |
| bus_rdata | input | 32 | Bus read data, valid when a read is accepted |

## Verification
The bench targets the following corner cases:

- **Zero-cycle stall.** The slave accepts on the first request clock. A design that delays clearing busy, or samples read data one edge late, returns stale bytes.
- **Long stall.** A design that does not hold the request lets the address or strobe move mid-cycle.
- **Commands and loads during a stall.** These must not restart the cycle, flip its direction or alter the address.
- **Go bit clear and unused selects.** A command with the go bit clear, and writes to unused selects, must leave the bridge idle. A loose decoder would launch a cycle or corrupt a register.
- **Byte order.** A lane swap in the register file shows up as a byte-reversed bus address.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_REQ = 2'd1,
        ST_WRITE_REQ = 2'd2
    } hb_state_e;

    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_DIR_BIT = 1;
    localparam int STS_BUSY_BIT = 0;

endpackage

// File: rtl/hb_byte_reg.sv
module hb_byte_reg #(
    parameter int W     = 32,
    parameter int HW    = 8,
    parameter int SEL_W = 4,
    parameter int BASE  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [HW-1:0]    wbyte,
    input  logic             cap_en,
    input  logic [W-1:0]     cap_val,
    output logic [W-1:0]     q
);
    localparam int LANES = W / HW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [SEL_W-1:0] LANE_SEL = SEL_W'(BASE + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i*HW +: HW] <= '0;
            end else if (cap_en) begin
                q[i*HW +: HW] <= cap_val[i*HW +: HW];
            end else if (ld_en && sel == LANE_SEL) begin
                q[i*HW +: HW] <= wbyte;
            end
        end
    end
endmodule

// File: rtl/hb_bus_fsm.sv
module hb_bus_fsm
    import hb_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int HW      = 8,
    parameter int CMD_SEL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [HW-1:0]    host_wbyte,
    input  logic             bus_waitreq,
    output logic             busy,
    output logic             bus_read,
    output logic             bus_write,
    output logic             rd_capture
);
    localparam logic [SEL_W-1:0] CMD_ADDR = SEL_W'(CMD_SEL);

    hb_state_e state, nxt;
    logic      go_hit;

    assign go_hit = host_wr && (host_sel == CMD_ADDR) && host_wbyte[CMD_GO_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go_hit) nxt = host_wbyte[CMD_DIR_BIT] ? ST_WRITE_REQ : ST_READ_REQ;
            end
            ST_READ_REQ, ST_WRITE_REQ: begin
                if (!bus_waitreq) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b0;
        bus_read   = 1'b0;
        bus_write  = 1'b0;
        rd_capture = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_READ_REQ: begin
                busy       = 1'b1;
                bus_read   = 1'b1;
                rd_capture = !bus_waitreq;
            end
            ST_WRITE_REQ: begin
                busy      = 1'b1;
                bus_write = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hb_rd_mux.sv
module hb_rd_mux
    import hb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int HW      = 8,
    parameter int SEL_W   = 4,
    parameter int STS_SEL = 9
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    input  logic              busy,
    output logic [HW-1:0]     rbyte
);
    localparam int ALANES = ADDR_W / HW;
    localparam int DLANES = DATA_W / HW;

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < ALANES; i++) begin
            if (sel == SEL_W'(i)) rbyte = addr_q[i*HW +: HW];
        end
        for (int j = 0; j < DLANES; j++) begin
            if (sel == SEL_W'(ALANES + j)) rbyte = data_q[j*HW +: HW];
        end
        if (sel == SEL_W'(STS_SEL)) rbyte[STS_BUSY_BIT] = busy;
    end
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int HW     = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_wr,
    input  logic [HW-1:0]     host_wdata,
    output logic [HW-1:0]     host_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_read,
    output logic              bus_write,
    input  logic              bus_waitreq,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int ALANES   = ADDR_W / HW;
    localparam int DLANES   = DATA_W / HW;
    localparam int DATA_SEL = ALANES;
    localparam int CMD_SEL  = ALANES + DLANES;
    localparam int STS_SEL  = CMD_SEL + 1;

    logic              busy;
    logic              rd_capture;
    logic              ld_en;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign ld_en = host_wr && !busy;

    hb_byte_reg #(.W(ADDR_W), .HW(HW), .SEL_W(SEL_W), .BASE(0)) u_addr (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .sel(host_sel),
        .wbyte(host_wdata), .cap_en(1'b0), .cap_val('0), .q(addr_q)
    );

    hb_byte_reg #(.W(DATA_W), .HW(HW), .SEL_W(SEL_W), .BASE(DATA_SEL)) u_data (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .sel(host_sel),
        .wbyte(host_wdata), .cap_en(rd_capture), .cap_val(bus_rdata), .q(data_q)
    );

    hb_bus_fsm #(.SEL_W(SEL_W), .HW(HW), .CMD_SEL(CMD_SEL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wbyte(host_wdata), .bus_waitreq(bus_waitreq), .busy(busy),
        .bus_read(bus_read), .bus_write(bus_write), .rd_capture(rd_capture)
    );

    hb_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HW(HW), .SEL_W(SEL_W),
                .STS_SEL(STS_SEL)) u_rmux (
        .sel(host_sel), .addr_q(addr_q), .data_q(data_q), .busy(busy),
        .rbyte(host_rdata)
    );

    assign bus_addr  = addr_q;
    assign bus_wdata = data_q;
endmodule

// File: rtl/hb_bridge_chk.sv
module hb_bridge_chk #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int HW      = 8,
    parameter int SEL_W   = 4,
    parameter int CMD_SEL = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  host_sel,
    input logic              host_wr,
    input logic [HW-1:0]     host_wdata,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_read,
    input logic              bus_write,
    input logic              bus_waitreq,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              busy,
    input logic [DATA_W-1:0] data_q
);
    localparam logic [SEL_W-1:0] CMD_ADDR = SEL_W'(CMD_SEL);

    // R10
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_read && bus_write));

    // R6
    p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_read || bus_write) && bus_waitreq) |=>
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_read) && $stable(bus_write)));

    // R4
    p_go_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == CMD_ADDR && host_wdata[0] && !busy) |=>
            (busy && bus_write == $past(host_wdata[1]) && bus_read == !$past(host_wdata[1])));

    // R5
    p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_read || bus_write) && !bus_waitreq) |=> !busy);

    // R7
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && !bus_waitreq) |=> (data_q == $past(bus_rdata)));

    // R8
    p_no_rego_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_waitreq && host_wr && host_sel == CMD_ADDR) |=>
            ($stable(bus_read) && $stable(bus_write)));

    // R9
    p_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_waitreq && host_wr) |=> ($stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind hostbus_bridge hb_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HW(HW), .SEL_W(SEL_W), .CMD_SEL(CMD_SEL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_read(bus_read), .bus_write(bus_write), .bus_waitreq(bus_waitreq),
    .bus_rdata(bus_rdata), .busy(busy), .data_q(data_q)
);

// File: tb/sim_hostbus_bridge.sv
`timescale 1ns/1ps
module sim_hostbus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_sel = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic        bus_read, bus_write;
    logic        bus_waitreq = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hostbus_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_read(bus_read), .bus_write(bus_write),
        .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata)
    );

    // {address, data, stall cycles, direction(1=write)}
    localparam logic [71:0] VEC [5] = '{
        {32'h0000_1000, 32'hDEAD_BEEF, 4'd0, 4'd1},
        {32'h8040_2010, 32'h0000_0000, 4'd0, 4'd0},
        {32'h1234_5678, 32'hA5A5_0F0F, 4'd5, 4'd1},
        {32'hFFFF_FFFC, 32'h1111_2222, 4'd7, 4'd0},
        {32'h0102_0304, 32'hCAFE_F00D, 4'd2, 4'd0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [3:0] sel, logic [7:0] val);
        @(negedge clk);
        host_sel = sel; host_wdata = val; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [3:0] sel, output logic [7:0] val);
        host_sel = sel;
        #1;
        val = host_rdata;
    endtask

    task automatic read_word(logic [3:0] base, output logic [31:0] w);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            hread(base + 4'(k), b);
            w[k*8 +: 8] = b;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w, a, d, rv, expd;
        logic        dir;
        int          stall;

        repeat (3) @(negedge clk);
        // R1 reset state
        hread(4'd9, b);      check("R1 status", 32'(b), 32'h0);
        check("R1 strobes", {30'b0, bus_read, bus_write}, 32'h0);
        check("R1 addr", bus_addr, 32'h0);
        read_word(4'd4, w);  check("R1 data", w, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 5; v++) begin
            a = VEC[v][71:40]; d = VEC[v][39:8];
            stall = int'(VEC[v][7:4]); dir = VEC[v][0];
            rv = ~a ^ 32'h5A5A_C3C3;
            for (int k = 0; k < 4; k++) hwrite(4'(k), a[k*8 +: 8]);
            for (int k = 0; k < 4; k++) hwrite(4'(4 + k), d[k*8 +: 8]);
            read_word(4'd0, w);  check("R2 addr readback", w, a);
            check("R2 bus_addr", bus_addr, a);
            check("R3 bus_wdata", bus_wdata, d);
            hwrite(4'd8, {6'b0, dir, 1'b1});
            hread(4'd9, b);      check("R5 busy set", 32'(b), 32'h1);
            check("R4 strobe", {30'b0, bus_read, bus_write}, {30'b0, !dir, dir});
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check("R6 addr held", bus_addr, a);
                check("R10 strobes", {30'b0, bus_read, bus_write}, {30'b0, !dir, dir});
            end
            bus_rdata = rv; bus_waitreq = 1'b0;
            @(negedge clk);
            bus_waitreq = 1'b1; bus_rdata = '0;
            hread(4'd9, b);      check("R5 busy clear", 32'(b), 32'h0);
            check("R5 strobes off", {30'b0, bus_read, bus_write}, 32'h0);
            expd = dir ? d : rv;
            read_word(4'd4, w);  check("R7 data word", w, expd);
        end

        // R4 go bit clear: no cycle
        hwrite(4'd8, 8'h02);
        hread(4'd9, b);  check("R4 no go", 32'(b), 32'h0);
        check("R4 no strobe", {30'b0, bus_read, bus_write}, 32'h0);

        // R8 / R9 activity during a stalled read
        for (int k = 0; k < 4; k++) hwrite(4'(k), 8'(8'h20 + k));
        hwrite(4'd8, 8'h01);
        hwrite(4'd0, 8'hFF);
        hwrite(4'd5, 8'hEE);
        hwrite(4'd8, 8'h03);
        check("R8 still read", {30'b0, bus_read, bus_write}, 32'h2);
        check("R9 addr kept", bus_addr, 32'h2322_2120);
        hread(4'd0, b);  check("R9 byte0 kept", 32'(b), 32'h20);
        bus_rdata = 32'h7654_3210; bus_waitreq = 1'b0;
        @(negedge clk);
        bus_waitreq = 1'b1;
        read_word(4'd4, w);  check("R7 capture after stall", w, 32'h7654_3210);

        // R11 unused selects
        hwrite(4'd12, 8'h55);
        hwrite(4'd15, 8'h03);
        hread(4'd12, b); check("R11 sel12 zero", 32'(b), 32'h0);
        hread(4'd8, b);  check("R11 cmd reads zero", 32'(b), 32'h0);
        hread(4'd9, b);  check("R11 idle", 32'(b), 32'h0);
        check("R11 addr kept", bus_addr, 32'h2322_2120);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule